// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block guards a non-volatile array against stray writes. It sits between the host bus interface and the page write controller and sees every write request, each carrying a 15-bit address and an 8-bit data byte. While the array is locked, the block swallows the writes. A fixed three-write command pattern unlocks it. After the unlock, data writes pass through to the page controller until the current page write operation closes.

The page controller owns the byte-load timer. It reports an expired window on `blw_expired`, which is also the event that closes a page write operation. Each absorbed command byte is reported on `cmd_ack`, so the page controller can restart its timer for the next command byte. The block reports discarded writes, broken sequences and its current progress through the pattern. All results are registered and appear one clock after the request.

Top module: `ulk_guard`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `stage` is 0 and `unlocked`, `fwd_valid`, `cmd_ack`, `wr_drop` and `seq_abort` are all low.
- R2: In stage 0, a write that is not data AAh at address 5555h is discarded: `wr_drop` pulses one cycle later, nothing is forwarded and `stage` stays 0. The address and the data must both match.
- R3: In stage 0, AAh at 5555h is absorbed. In stage 1, 55h at 2AAAh is absorbed. In stage 2, A0h at 5555h is absorbed. Each absorbed byte pulses `cmd_ack` and moves `stage` to 1, 2 or 3 respectively. No command byte is ever forwarded.
- R4: In stage 3 (`unlocked` high), every write is forwarded with `fwd_valid` one cycle later, carrying the same address and data. This includes writes whose values equal command bytes. `stage` stays 3.
- R5: In stage 1 or 2, a write that breaks the pattern pulses `seq_abort`. If the write is AAh at 5555h, it is absorbed (`cmd_ack`) and `stage` becomes 1. Otherwise it is discarded (`wr_drop`) and `stage` becomes 0.
- R6: A `blw_expired` pulse in stage 1 or 2 returns `stage` to 0 and pulses `seq_abort`.
- R7: A `blw_expired` pulse in stage 3 returns `stage` to 0 without `seq_abort`. The next write then needs the full pattern again.
- R8: When `blw_expired` and a write arrive in the same cycle, the expiry is applied first and the write is judged from stage 0.
- R9: A `blw_expired` pulse in stage 0 with no write has no effect: no output pulse, and `stage` stays 0.
- R10: Each write request yields exactly one of `fwd_valid`, `cmd_ack` or `wr_drop` one cycle later. None of the three pulses without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe, one cycle per write |
| req_addr | input | 15 | Write address |
| req_data | input | 8 | Write data |
| blw_expired | input | 1 | Byte-load window expired; closes the page operation |
| fwd_valid | output | 1 | Forwarded data write to the page controller |
| fwd_addr | output | 15 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| cmd_ack | output | 1 | A command byte was absorbed |
| wr_drop | output | 1 | A write was discarded |
| seq_abort | output | 1 | A partly entered pattern was broken |
| stage | output | 2 | Progress: 0 locked, 1 and 2 partial, 3 unlocked |
| unlocked | output | 1 | High in stage 3 |

## Verification
The hardest cases to reach are the collisions between a window expiry and a write in the same cycle. The stimulus places an expiry on the very cycle that carries the final A0h byte, which must be judged from the locked state and dropped. It also places an expiry on a cycle that carries AAh at 5555h while unlocked, which must restart the pattern rather than be forwarded. The broken-pattern case that restarts at stage 1 is also exercised: a second AAh at 5555h arrives in stage 2.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_GOT1   = 2'd1,
    ST_GOT2   = 2'd2,
    ST_OPEN   = 2'd3
  } ulk_state_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_FWD  = 2'd1,
    EV_CMD  = 2'd2,
    EV_DROP = 2'd3
  } ulk_ev_e;
endpackage

// File: rtl/ulk_match.sv
module ulk_match #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int N_CMD  = 3,
  parameter logic [N_CMD*ADDR_W-1:0] ADDR_SEQ = '0,
  parameter logic [N_CMD*DATA_W-1:0] DATA_SEQ = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [N_CMD-1:0]  hit
);
  // one comparator per command byte of the pattern
  for (genvar i = 0; i < N_CMD; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_REF = ADDR_SEQ[i*ADDR_W +: ADDR_W];
    localparam logic [DATA_W-1:0] D_REF = DATA_SEQ[i*DATA_W +: DATA_W];
    assign hit[i] = (addr == A_REF) && (data == D_REF);
  end
endmodule

// File: rtl/ulk_seq.sv
module ulk_seq
  import ulk_pkg::*;
#(
  parameter int N_CMD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [N_CMD-1:0] hit,
  input  logic             expired,
  output ulk_state_e       state_q,
  output ulk_ev_e          ev_kind,
  output logic             ev_abort
);
  ulk_state_e state_d;
  ulk_state_e base;

  always_comb begin
    // an expiry is applied before a write of the same cycle
    base     = expired ? ST_LOCKED : state_q;
    ev_abort = expired && (state_q == ST_GOT1 || state_q == ST_GOT2);
    ev_kind  = EV_NONE;
    state_d  = base;
    if (req_valid) begin
      unique case (base)
        ST_LOCKED: begin
          if (hit[0]) begin
            state_d = ST_GOT1;
            ev_kind = EV_CMD;
          end else begin
            ev_kind = EV_DROP;
          end
        end
        ST_GOT1, ST_GOT2: begin
          if ((base == ST_GOT1 && hit[1]) || (base == ST_GOT2 && hit[2])) begin
            state_d = (base == ST_GOT1) ? ST_GOT2 : ST_OPEN;
            ev_kind = EV_CMD;
          end else if (hit[0]) begin
            state_d  = ST_GOT1;
            ev_kind  = EV_CMD;
            ev_abort = 1'b1;
          end else begin
            state_d  = ST_LOCKED;
            ev_kind  = EV_DROP;
            ev_abort = 1'b1;
          end
        end
        default: begin
          ev_kind = EV_FWD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ulk_emit.sv
module ulk_emit
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  ulk_ev_e           ev_kind,
  input  logic              ev_abort,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              cmd_ack,
  output logic              wr_drop,
  output logic              seq_abort
);
  logic cap_en;
  assign cap_en = req_valid && (ev_kind == EV_FWD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      cmd_ack   <= 1'b0;
      wr_drop   <= 1'b0;
      seq_abort <= 1'b0;
    end else begin
      fwd_valid <= (ev_kind == EV_FWD);
      cmd_ack   <= (ev_kind == EV_CMD);
      wr_drop   <= (ev_kind == EV_DROP);
      seq_abort <= ev_abort;
    end
  end

  // payload register, clock-enabled on forwarded writes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_addr <= '0;
      fwd_data <= '0;
    end else if (cap_en) begin
      fwd_addr <= req_addr;
      fwd_data <= req_data;
    end
  end
endmodule

// File: rtl/ulk_guard.sv
module ulk_guard
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD0_ADDR = 15'h5555,
  parameter logic [DATA_W-1:0] CMD0_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] CMD1_ADDR = 15'h2AAA,
  parameter logic [DATA_W-1:0] CMD1_DATA = 8'h55,
  parameter logic [ADDR_W-1:0] CMD2_ADDR = 15'h5555,
  parameter logic [DATA_W-1:0] CMD2_DATA = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              blw_expired,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              cmd_ack,
  output logic              wr_drop,
  output logic              seq_abort,
  output logic [1:0]        stage,
  output logic              unlocked
);
  localparam int N_CMD = 3;
  localparam logic [N_CMD*ADDR_W-1:0] ADDR_SEQ = {CMD2_ADDR, CMD1_ADDR, CMD0_ADDR};
  localparam logic [N_CMD*DATA_W-1:0] DATA_SEQ = {CMD2_DATA, CMD1_DATA, CMD0_DATA};

  // reset asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [N_CMD-1:0] hit;
  ulk_state_e       state_q;
  ulk_ev_e          ev_kind;
  logic             ev_abort;

  ulk_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CMD(N_CMD),
    .ADDR_SEQ(ADDR_SEQ), .DATA_SEQ(DATA_SEQ)
  ) u_match (
    .addr(req_addr), .data(req_data), .hit(hit)
  );

  ulk_seq #(.N_CMD(N_CMD)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .hit(hit),
    .expired(blw_expired), .state_q(state_q), .ev_kind(ev_kind),
    .ev_abort(ev_abort)
  );

  ulk_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_emit (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .ev_kind(ev_kind),
    .ev_abort(ev_abort), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .cmd_ack(cmd_ack), .wr_drop(wr_drop),
    .seq_abort(seq_abort)
  );

  assign stage    = state_q;
  assign unlocked = (state_q == ST_OPEN);
endmodule

// File: rtl/ulk_guard_chk.sv
module ulk_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       blw_expired,
  input logic       fwd_valid,
  input logic       cmd_ack,
  input logic       wr_drop,
  input logic       seq_abort,
  input logic [1:0] stage,
  input logic       unlocked
);
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({fwd_valid, cmd_ack, wr_drop}) == 1);

  p_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(fwd_valid || cmd_ack || wr_drop));

  p_fwd_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> unlocked);

  p_cmd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> stage != 2'd0);

  p_abort_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> stage <= 2'd1);

  p_open_via_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(stage) == 2'd2);

  p_expire_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blw_expired && !req_valid) |=> stage == 2'd0);

  p_drop_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> stage == 2'd0);
endmodule

bind ulk_guard ulk_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .blw_expired(blw_expired),
  .fwd_valid(fwd_valid), .cmd_ack(cmd_ack), .wr_drop(wr_drop),
  .seq_abort(seq_abort), .stage(stage), .unlocked(unlocked)
);

// File: tb/ulk_guard_test.sv
module ulk_guard_test;
  localparam int K_NONE = 0, K_FWD = 1, K_CMD = 2, K_DROP = 3;

  typedef struct {
    int          kind;
    logic        abort;
    logic [14:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        blw_expired = 1'b0;
  logic        fwd_valid, cmd_ack, wr_drop, seq_abort, unlocked;
  logic [14:0] fwd_addr;
  logic [7:0]  fwd_data;
  logic [1:0]  stage;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  ulk_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .blw_expired(blw_expired), .fwd_valid(fwd_valid),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .cmd_ack(cmd_ack),
    .wr_drop(wr_drop), .seq_abort(seq_abort), .stage(stage),
    .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare each result pulse against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int   kind;
      exp_t e;
      kind = fwd_valid ? K_FWD : cmd_ack ? K_CMD : wr_drop ? K_DROP : K_NONE;
      if ((fwd_valid + cmd_ack + wr_drop) > 1) kind = 7;
      if (kind != K_NONE || seq_abort) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", kind, K_NONE);
        end else begin
          e = q.pop_front();
          check(kind == e.kind, e.tag, "result kind", kind, e.kind);
          check(seq_abort == e.abort, e.tag, "abort", seq_abort, e.abort);
          if (e.kind == K_FWD && kind == K_FWD) begin
            check(fwd_addr == e.addr, e.tag, "fwd addr", fwd_addr, e.addr);
            check(fwd_data == e.data, e.tag, "fwd data", fwd_data, e.data);
          end
        end
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed, stage checked after
  task automatic step(input bit wr, input logic [14:0] a, input logic [7:0] d,
                      input bit tmo, input int kind, input bit abort,
                      input int st, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid   = wr;
    req_addr    = a;
    req_data    = d;
    blw_expired = tmo;
    if (kind != K_NONE || abort) begin
      e.kind = kind; e.abort = abort; e.addr = a; e.data = d; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    req_valid   = 1'b0;
    blw_expired = 1'b0;
    check(stage == 2'(st), tag, "stage", stage, st);
    check(unlocked == (st == 3), tag, "unlocked", unlocked, st == 3);
  endtask

  task automatic unlock(input string tag);
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, tag);
    step(1, 15'h2AAA, 8'h55, 0, K_CMD, 0, 2, tag);
    step(1, 15'h5555, 8'hA0, 0, K_CMD, 0, 3, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while held in reset
    check(stage == 0 && !unlocked, "R1", "stage in reset", stage, 0);
    check(!(fwd_valid | cmd_ack | wr_drop | seq_abort), "R1", "pulses in reset",
          {fwd_valid, cmd_ack, wr_drop, seq_abort}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(stage == 0, "R1", "stage after reset", stage, 0);

    // R2: locked writes are discarded
    step(1, 15'h0100, 8'h12, 0, K_DROP, 0, 0, "R2");
    step(1, 15'h2AAA, 8'h55, 0, K_DROP, 0, 0, "R2");
    step(1, 15'h5554, 8'hAA, 0, K_DROP, 0, 0, "R2");
    step(1, 15'h5555, 8'hAB, 0, K_DROP, 0, 0, "R2");
    // R9: expiry while locked does nothing
    step(0, 15'h0, 8'h0, 1, K_NONE, 0, 0, "R9");

    // R3 and R4: unlock, then data passes including command-like values
    unlock("R3");
    step(1, 15'h1234, 8'h3C, 0, K_FWD, 0, 3, "R4");
    step(1, 15'h5555, 8'hAA, 0, K_FWD, 0, 3, "R4");
    step(1, 15'h1235, 8'hA0, 0, K_FWD, 0, 3, "R4");
    // R7: expiry closes the operation without abort; relock
    step(0, 15'h0, 8'h0, 1, K_NONE, 0, 0, "R7");
    step(1, 15'h1236, 8'h77, 0, K_DROP, 0, 0, "R7");

    // R5: broken pattern
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, "R5");
    step(1, 15'h2AAA, 8'h56, 0, K_DROP, 1, 0, "R5");
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, "R5");
    step(1, 15'h2AAA, 8'h55, 0, K_CMD, 0, 2, "R5");
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 1, 1, "R5");
    step(1, 15'h2AAA, 8'h55, 0, K_CMD, 0, 2, "R5");
    step(1, 15'h5555, 8'hA0, 0, K_CMD, 0, 3, "R5");
    step(1, 15'h0042, 8'hE1, 0, K_FWD, 0, 3, "R5");
    step(0, 15'h0, 8'h0, 1, K_NONE, 0, 0, "R7");

    // R6: expiry during partial pattern
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, "R6");
    step(0, 15'h0, 8'h0, 1, K_NONE, 1, 0, "R6");
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, "R6");
    step(1, 15'h2AAA, 8'h55, 0, K_CMD, 0, 2, "R6");
    step(0, 15'h0, 8'h0, 1, K_NONE, 1, 0, "R6");

    // R8: expiry and write in the same cycle
    step(1, 15'h5555, 8'hAA, 0, K_CMD, 0, 1, "R8");
    step(1, 15'h2AAA, 8'h55, 0, K_CMD, 0, 2, "R8");
    step(1, 15'h5555, 8'hA0, 1, K_DROP, 1, 0, "R8");
    unlock("R8");
    step(1, 15'h5555, 8'hAA, 1, K_CMD, 0, 1, "R8");
    step(0, 15'h0, 8'h0, 1, K_NONE, 1, 0, "R8");

    // R1: reset while unlocked forces the locked state
    unlock("R1");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(stage == 0 && !unlocked, "R1", "stage after mid reset", stage, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(1, 15'h0077, 8'h11, 0, K_DROP, 0, 0, "R1");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10", "pending expectations", q.size(), 0);
    finish_run();
  end
endmodule